// File: doc/BRIEF.md
# Virtual NIC MAC Mapping Table

A small exact-match table that sits in a multi-port NIC packet pipeline and gives every virtual interface three things: a 48-bit MAC identity, a host receive queue and a physical transmit port. One table serves both directions. A frame arriving from the wire (direction 0) is looked up by its destination MAC. A hit steers it to the host queue stored in the matching entry, and a miss drops it at once. A frame coming from the host (direction 1) is looked up by its source MAC. A hit marks the sender as legitimate and pins the frame to that entry's physical port. A miss drops it. When the `blk_en` input is high, a host frame whose source and destination MACs both hit the table is dropped, which stops VM-to-VM traffic on the same server.

An administrator port rewrites one whole entry per write cycle (valid bit, MAC, queue and port together) while traffic flows, so a lookup never sees a half-written entry. Lookups are fully pipelined with one request per cycle. The verdict appears exactly two cycles after the request. Each verdict is one of four enumerated outcomes:
- PASS (code 0)
- RX_MISS (code 1)
- TX_NOSRC (code 2)
- VM_BLOCK (code 3)

Transitions per request: rx hit gives PASS and rx miss gives RX_MISS. For tx, a source miss gives TX_NOSRC. A source hit gives VM_BLOCK if blocking is on and the destination also hits, and PASS otherwise.

Top module: `vnic_map_lookup`

## Requirements
- R1: An rx request (req_dir=0) whose destination MAC equals a valid entry gives rsp_fwd=1, rsp_cause=0, rsp_idx=that entry and rsp_dest=the entry's receive queue.
- R2: An rx request whose destination MAC matches no valid entry gives rsp_fwd=0, rsp_cause=1, rsp_idx=0, rsp_dest=0.
- R3: A tx request (req_dir=1) whose source MAC hits gives rsp_fwd=1, rsp_cause=0, rsp_idx=the source entry and rsp_dest=that entry's transmit port (unless R5 drops it).
- R4: A tx request whose source MAC misses is dropped with rsp_cause=2, rsp_idx=0, rsp_dest=0, whatever its destination MAC.
- R5: With blk_en=1, a tx request whose source and destination MACs both hit is dropped with rsp_cause=3, rsp_idx=source entry, rsp_dest=0. With blk_en=0 the same request is forwarded per R3.
- R6: When several valid entries hold the same MAC, the lowest index wins.
- R7: An entry whose valid bit is 0 never matches. Reset clears every valid bit.
- R8: A write with cfg_we=1 replaces valid, MAC, queue and port of entry cfg_idx in one edge. A lookup requested in the same cycle as the write already sees the new entry.
- R9: rsp_vld rises exactly two cycles after req_vld is sampled, with one response per request and back-to-back requests allowed. While rsp_vld=0, rsp_fwd, rsp_cause, rsp_idx and rsp_dest are 0. rsp_fwd=1 exactly when rsp_cause=0.
- R10: rx lookups ignore the source MAC and blk_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Entry write strobe |
| cfg_idx | input | 5 | Entry index to write |
| cfg_valid | input | 1 | Valid bit for written entry |
| cfg_mac | input | 48 | MAC for written entry |
| cfg_rxq | input | 2 | Host receive queue for written entry |
| cfg_txp | input | 2 | Physical transmit port for written entry |
| blk_en | input | 1 | Enable VM-to-VM blocking on tx |
| req_vld | input | 1 | Lookup request valid |
| req_dir | input | 1 | 0 = rx from wire, 1 = tx from host |
| req_dmac | input | 48 | Frame destination MAC |
| req_smac | input | 48 | Frame source MAC |
| rsp_vld | output | 1 | Verdict valid |
| rsp_fwd | output | 1 | Frame forwarded (1) or dropped (0) |
| rsp_cause | output | 2 | Verdict code 0..3 |
| rsp_idx | output | 5 | Matching entry index |
| rsp_dest | output | 2 | Receive queue (rx) or transmit port (tx) |

## Verification
The table is loaded with entries at the first and last index, plus two entries that share a MAC. Rx lookups then hit each of these, miss, and carry a source MAC that would hit; together they separate correct steering from priority mistakes and from keying on the wrong address. The tx patterns cover a source hit with a foreign destination, both hits with blocking on and off, and a source miss with a destination hit. These isolate the legitimacy check from the VM-to-VM block. Directed cases cover lookups straight after reset with all-zero MACs, an invalidated entry, a rewrite issued in the same cycle as its lookup, and back-to-back requests for pipelining and latency.

// File: rtl/vnic_map_pkg.sv
package vnic_map_pkg;
    localparam int MAC_W = 48;

    typedef enum logic [1:0] {
        VD_PASS     = 2'd0,
        VD_RX_MISS  = 2'd1,
        VD_TX_NOSRC = 2'd2,
        VD_VM_BLOCK = 2'd3
    } verdict_e;
endpackage

// File: rtl/vnic_map_store.sv
module vnic_map_store
    import vnic_map_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IW    = 5,
    parameter int QW    = 2,
    parameter int PW    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IW-1:0]    wr_idx,
    input  logic             wr_valid,
    input  logic [MAC_W-1:0] wr_mac,
    input  logic [QW-1:0]    wr_rxq,
    input  logic [PW-1:0]    wr_txp,
    output logic [N_ENT-1:0] ent_valid,
    output logic [MAC_W-1:0] ent_mac [N_ENT],
    output logic [QW-1:0]    ent_rxq [N_ENT],
    output logic [PW-1:0]    ent_txp [N_ENT]
);
    // Whole entry written in one edge: no torn entry is ever visible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) begin
                ent_valid[i] <= 1'b0;
                ent_mac[i]   <= '0;
                ent_rxq[i]   <= '0;
                ent_txp[i]   <= '0;
            end
        end else if (wr_en) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (wr_idx == IW'(i)) begin
                    ent_valid[i] <= wr_valid;
                    ent_mac[i]   <= wr_mac;
                    ent_rxq[i]   <= wr_rxq;
                    ent_txp[i]   <= wr_txp;
                end
            end
        end
    end
endmodule

// File: rtl/vnic_map_match.sv
module vnic_map_match
    import vnic_map_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int IW    = 5
) (
    input  logic [MAC_W-1:0] key,
    input  logic [N_ENT-1:0] ent_valid,
    input  logic [MAC_W-1:0] ent_mac [N_ENT],
    output logic             hit,
    output logic [IW-1:0]    idx
);
    logic [N_ENT-1:0] eq;

    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign eq[g] = ent_valid[g] && (ent_mac[g] == key);
    end

    // Lowest matching index wins.
    always_comb begin
        hit = |eq;
        idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (eq[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/vnic_map_lookup.sv
module vnic_map_lookup
    import vnic_map_pkg::*;
#(
    parameter int N_ENT = 32,
    parameter int N_RXQ = 4,
    parameter int N_TXP = 4,
    parameter int IW    = $clog2(N_ENT),
    parameter int QW    = $clog2(N_RXQ),
    parameter int PW    = $clog2(N_TXP),
    parameter int DW    = (QW > PW) ? QW : PW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IW-1:0]    cfg_idx,
    input  logic             cfg_valid,
    input  logic [MAC_W-1:0] cfg_mac,
    input  logic [QW-1:0]    cfg_rxq,
    input  logic [PW-1:0]    cfg_txp,
    input  logic             blk_en,
    input  logic             req_vld,
    input  logic             req_dir,
    input  logic [MAC_W-1:0] req_dmac,
    input  logic [MAC_W-1:0] req_smac,
    output logic             rsp_vld,
    output logic             rsp_fwd,
    output logic [1:0]       rsp_cause,
    output logic [IW-1:0]    rsp_idx,
    output logic [DW-1:0]    rsp_dest
);
    logic [N_ENT-1:0] ent_valid;
    logic [MAC_W-1:0] ent_mac [N_ENT];
    logic [QW-1:0]    ent_rxq [N_ENT];
    logic [PW-1:0]    ent_txp [N_ENT];

    vnic_map_store #(.N_ENT(N_ENT), .IW(IW), .QW(QW), .PW(PW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_valid (cfg_valid),
        .wr_mac   (cfg_mac),
        .wr_rxq   (cfg_rxq),
        .wr_txp   (cfg_txp),
        .ent_valid(ent_valid),
        .ent_mac  (ent_mac),
        .ent_rxq  (ent_rxq),
        .ent_txp  (ent_txp)
    );

    // Stage 1: capture request.
    logic             st_vld, st_dir, st_blk;
    logic [MAC_W-1:0] st_dmac, st_smac;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_vld  <= 1'b0;
            st_dir  <= 1'b0;
            st_blk  <= 1'b0;
            st_dmac <= '0;
            st_smac <= '0;
        end else begin
            st_vld  <= req_vld;
            st_dir  <= req_dir;
            st_blk  <= blk_en;
            st_dmac <= req_dmac;
            st_smac <= req_smac;
        end
    end

    logic          d_hit, s_hit;
    logic [IW-1:0] d_idx, s_idx;

    vnic_map_match #(.N_ENT(N_ENT), .IW(IW)) u_dmatch (
        .key(st_dmac), .ent_valid(ent_valid), .ent_mac(ent_mac),
        .hit(d_hit), .idx(d_idx)
    );

    vnic_map_match #(.N_ENT(N_ENT), .IW(IW)) u_smatch (
        .key(st_smac), .ent_valid(ent_valid), .ent_mac(ent_mac),
        .hit(s_hit), .idx(s_idx)
    );

    // Stage 2: verdict.
    verdict_e      nx_vd;
    logic          nx_fwd;
    logic [IW-1:0] nx_idx;
    logic [DW-1:0] nx_dest;

    always_comb begin
        nx_vd   = VD_PASS;
        nx_fwd  = 1'b0;
        nx_idx  = '0;
        nx_dest = '0;
        if (st_vld) begin
            unique case (st_dir)
                1'b0: begin
                    if (d_hit) begin
                        nx_fwd  = 1'b1;
                        nx_idx  = d_idx;
                        nx_dest = DW'(ent_rxq[d_idx]);
                    end else begin
                        nx_vd = VD_RX_MISS;
                    end
                end
                1'b1: begin
                    if (!s_hit) begin
                        nx_vd = VD_TX_NOSRC;
                    end else begin
                        nx_idx = s_idx;
                        if (st_blk && d_hit) begin
                            nx_vd = VD_VM_BLOCK;
                        end else begin
                            nx_fwd  = 1'b1;
                            nx_dest = DW'(ent_txp[s_idx]);
                        end
                    end
                end
                default: nx_vd = VD_PASS;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_vld   <= 1'b0;
            rsp_fwd   <= 1'b0;
            rsp_cause <= '0;
            rsp_idx   <= '0;
            rsp_dest  <= '0;
        end else begin
            rsp_vld   <= st_vld;
            rsp_fwd   <= nx_fwd;
            rsp_cause <= nx_vd;
            rsp_idx   <= nx_idx;
            rsp_dest  <= nx_dest;
        end
    end
endmodule

// File: rtl/vnic_map_lookup_chk.sv
module vnic_map_lookup_chk #(
    parameter int IW = 5,
    parameter int DW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_vld,
    input logic          req_dir,
    input logic          blk_en,
    input logic          rsp_vld,
    input logic          rsp_fwd,
    input logic [1:0]    rsp_cause,
    input logic [IW-1:0] rsp_idx,
    input logic [DW-1:0] rsp_dest
);
    logic [1:0] cyc;
    always_ff @(posedge clk) begin
        if (!rst_n)        cyc <= 2'd0;
        else if (cyc != 2) cyc <= cyc + 2'd1;
    end

    // R9: verdict exactly two cycles after the request
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2) |-> (rsp_vld == $past(req_vld, 2)));

    // R9: quiet outputs when no verdict
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> (!rsp_fwd && rsp_cause == 2'd0 && rsp_idx == '0 && rsp_dest == '0));

    // R9: forward flag agrees with verdict code
    a_r9_fwd_code: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_vld |-> (rsp_fwd == (rsp_cause == 2'd0)));

    // R2: a dropped frame carries no destination
    a_r2_drop_dest: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_vld && !rsp_fwd) |-> (rsp_dest == '0));

    // R4: tx-only causes come from tx requests
    a_r4_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && rsp_vld && rsp_cause[1]) |-> $past(req_dir, 2));

    // R5: a VM-to-VM block needs blocking enabled
    a_r5_block_en: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && rsp_vld && rsp_cause == 2'd3) |-> $past(blk_en, 2));

    // R10: rx requests only ever yield pass or miss
    a_r10_rx_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == 2'd2 && rsp_vld && !$past(req_dir, 2)) |-> !rsp_cause[1]);
endmodule

bind vnic_map_lookup vnic_map_lookup_chk #(.IW(IW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_dir(req_dir),
    .blk_en(blk_en), .rsp_vld(rsp_vld), .rsp_fwd(rsp_fwd),
    .rsp_cause(rsp_cause), .rsp_idx(rsp_idx), .rsp_dest(rsp_dest)
);

// File: tb/vnic_map_lookup_tb.sv
module vnic_map_lookup_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_valid = 1'b0;
    logic [4:0]  cfg_idx = '0;
    logic [47:0] cfg_mac = '0;
    logic [1:0]  cfg_rxq = '0, cfg_txp = '0;
    logic        blk_en = 1'b0, req_vld = 1'b0, req_dir = 1'b0;
    logic [47:0] req_dmac = '0, req_smac = '0;
    logic        rsp_vld, rsp_fwd;
    logic [1:0]  rsp_cause, rsp_dest;
    logic [4:0]  rsp_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    vnic_map_lookup u_dut (.*);

    localparam logic [47:0] M10 = 48'h0200_0000_0010;
    localparam logic [47:0] M33 = 48'h0200_0000_0033;
    localparam logic [47:0] M44 = 48'h0200_0000_0044;
    localparam logic [47:0] M55 = 48'h0200_0000_0055;
    localparam logic [47:0] M77 = 48'h0200_0000_0077;
    localparam logic [47:0] M99 = 48'h0200_0000_0099;
    localparam logic [47:0] M1F = 48'h0200_0000_001F;

    typedef struct packed {
        logic        dir;
        logic        blk;
        logic [47:0] dmac;
        logic [47:0] smac;
        logic        fwd;
        logic [1:0]  cause;
        logic [4:0]  idx;
        logic [1:0]  dest;
    } vec_t;

    // Table: idx0 M10 q1 p3, idx3 M33 q2 p1, idx7 M77 q3 p2, idx9 M77 q0 p0, idx31 M1F q0 p2
    localparam vec_t VEC [11] = '{
        '{1'b0, 1'b0, M10, M99, 1'b1, 2'd0, 5'd0,  2'd1}, // R1 first entry
        '{1'b0, 1'b0, M33, M99, 1'b1, 2'd0, 5'd3,  2'd2}, // R1
        '{1'b0, 1'b0, M77, M99, 1'b1, 2'd0, 5'd7,  2'd3}, // R6 lowest of 7/9
        '{1'b0, 1'b1, M1F, M10, 1'b1, 2'd0, 5'd31, 2'd0}, // R10 last entry, smac/blk ignored
        '{1'b0, 1'b0, M55, M99, 1'b0, 2'd1, 5'd0,  2'd0}, // R2 miss
        '{1'b1, 1'b1, M99, M10, 1'b1, 2'd0, 5'd0,  2'd3}, // R3
        '{1'b1, 1'b1, M10, M33, 1'b0, 2'd3, 5'd3,  2'd0}, // R5 blocked
        '{1'b1, 1'b0, M10, M33, 1'b1, 2'd0, 5'd3,  2'd1}, // R5 block off
        '{1'b1, 1'b1, M10, M55, 1'b0, 2'd2, 5'd0,  2'd0}, // R4 src miss
        '{1'b1, 1'b1, M99, M77, 1'b1, 2'd0, 5'd7,  2'd2}, // R6 tx priority
        '{1'b0, 1'b0, M99, M10, 1'b0, 2'd1, 5'd0,  2'd0}  // R10 rx keys on dmac only
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:    return "R1";
            2, 9:    return "R6";
            3, 10:   return "R10";
            4:       return "R2";
            5:       return "R3";
            6, 7:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rsp_now();
        return {5'd0, rsp_vld, rsp_fwd, rsp_cause, rsp_idx, rsp_dest};
    endfunction

    function automatic logic [15:0] mk(logic fwd, logic [1:0] c, logic [4:0] i, logic [1:0] d);
        return {5'd0, 1'b1, fwd, c, i, d};
    endfunction

    task automatic wr(logic [4:0] i, logic v, logic [47:0] m, logic [1:0] q, logic [1:0] p);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = i; cfg_valid = v; cfg_mac = m; cfg_rxq = q; cfg_txp = p;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive(logic d, logic b, logic [47:0] dm, logic [47:0] sm);
        req_vld = 1'b1; req_dir = d; blk_en = b; req_dmac = dm; req_smac = sm;
    endtask

    // Issue one lookup at a negedge; check silence then the verdict.
    task automatic look(string tag, logic d, logic b, logic [47:0] dm, logic [47:0] sm,
                        logic [15:0] exp);
        @(negedge clk);
        drive(d, b, dm, sm);
        @(negedge clk);
        req_vld = 1'b0;
        check({tag, " no early verdict (R9)"}, rsp_now(), 16'd0);
        @(negedge clk);
        check(tag, rsp_now(), exp);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset quiet", rsp_now(), 16'd0);
        rst_n = 1'b1;

        // R7: cleared table matches nothing, not even an all-zero MAC
        look("R7 rx after reset", 1'b0, 1'b0, 48'd0, 48'd0, mk(1'b0, 2'd1, 5'd0, 2'd0));
        look("R7 tx after reset", 1'b1, 1'b0, 48'd0, 48'd0, mk(1'b0, 2'd2, 5'd0, 2'd0));

        wr(5'd0,  1'b1, M10, 2'd1, 2'd3);
        wr(5'd3,  1'b1, M33, 2'd2, 2'd1);
        wr(5'd7,  1'b1, M77, 2'd3, 2'd2);
        wr(5'd9,  1'b1, M77, 2'd0, 2'd0);
        wr(5'd31, 1'b1, M1F, 2'd0, 2'd2);

        for (int i = 0; i < 11; i++) begin
            look(vtag(i), VEC[i].dir, VEC[i].blk, VEC[i].dmac, VEC[i].smac,
                 mk(VEC[i].fwd, VEC[i].cause, VEC[i].idx, VEC[i].dest));
        end

        // R9: back-to-back requests, one verdict each, in order
        @(negedge clk);
        drive(1'b0, 1'b0, M33, 48'd0);
        @(negedge clk);
        drive(1'b1, 1'b0, M99, M77);
        @(negedge clk);
        req_vld = 1'b0;
        check("R9 b2b first", rsp_now(), mk(1'b1, 2'd0, 5'd3, 2'd2));
        @(negedge clk);
        check("R9 b2b second", rsp_now(), mk(1'b1, 2'd0, 5'd7, 2'd2));
        @(negedge clk);
        check("R9 b2b drained", rsp_now(), 16'd0);

        // R7: invalidating entry 7 leaves entry 9 as the M77 match
        wr(5'd7, 1'b0, M77, 2'd3, 2'd2);
        look("R7 invalid skipped", 1'b0, 1'b0, M77, 48'd0, mk(1'b1, 2'd0, 5'd9, 2'd0));

        // R8: rewrite of entry 3 in the same cycle as its lookup
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 5'd3; cfg_valid = 1'b1; cfg_mac = M44;
        cfg_rxq = 2'd1; cfg_txp = 2'd0;
        drive(1'b0, 1'b0, M44, 48'd0);
        @(negedge clk);
        cfg_we = 1'b0; req_vld = 1'b0;
        @(negedge clk);
        check("R8 same-cycle rewrite", rsp_now(), mk(1'b1, 2'd0, 5'd3, 2'd1));
        look("R8 old MAC gone", 1'b0, 1'b0, M33, 48'd0, mk(1'b0, 2'd1, 5'd0, 2'd0));
        look("R8 new port used", 1'b1, 1'b0, M99, M44, mk(1'b1, 2'd0, 5'd3, 2'd0));

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule